// File: doc/BRIEF.md
# Trouble Recorder Card Sequencer

This block drives a telephony trouble-recorder card through a scan/distribute bus master. It owns the whole recording handshake. After reset it releases the card's busy condition. It then watches the two start indications. When either appears, it reads the nine relay rows of the card, from the highest row to the lowest. It delivers the collected word, and then completes the record by closing a "record complete" point. That point stays closed until the start indications drop, is held for a further timed interval, and is then opened again.

The block talks to the bus master through a simple request/acknowledge port. A request and its address and data stay steady until a one-cycle acknowledge arrives, and read data is valid during that acknowledge cycle. Distribute writes always send a whole 6-bit row. The block keeps a local image of all four distribute rows, so changing one point leaves its neighbours in the same row as they were. The assembled card word comes out with a one-cycle valid strobe. Interpreting it is left to the consumer.

Top module: `trc_sequencer`

## Requirements
- R1: While reset is held, card_valid and card_data are 0. The first bus transaction after reset is a write to distribute row 2 that clears bit 0 (make-busy). The other bits of that row keep the power-up image given by DIST_RESET, where bit r*6+b holds row r, bit b.
- R2: While idle, the block issues only reads of scan row 0. A new read is raised in the cycle after the previous acknowledge.
- R3: A row-0 read that returns bit 9 (start) or bit 8 (auxiliary start) set begins a card read. The next request is the write that closes the point of relay row 8.
- R4: Relay rows are read in order 8, 7, ..., 0. Relay row r (r < 6) is selected by distribute row 3, bit r. Relay row r (r >= 6) is selected by distribute row 0, bit r-6.
- R5: For each relay row, the sequence is: a write that closes its point; a read of scan row TC_SCAN_ROW raised DWELL_CYC cycles after that write is acknowledged; and a write that opens the point, raised in the cycle after the read is acknowledged. A read of TC_SCAN_ROW is only made while exactly one relay point is closed.
- R6: After the opening write of row 0 is acknowledged and SETTLE_CYC cycles have passed, card_valid is high for exactly one cycle. card_data[r*10 +: 10] then holds the data read for relay row r, so row 8 is in bits 89:80.
- R7: In the cycle after card_valid, the block requests a write that closes the record-complete point (row 1, bit 5). It then reads scan row 0 repeatedly for as long as bit 9 or bit 8 reads set.
- R8: Once a row-0 read returns both bits clear, no request is made for HOLD_CYC cycles. The block then writes the record-complete point open and returns to idle polling.
- R9: Every distribute write changes at most one bit relative to the last value written to that row (or the power-up image).
- R10: Once raised, a request holds its direction, address and write data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 = distribute write, 0 = scan read |
| bus_addr | output | 4 | Scan row, or distribute row in the low 2 bits |
| bus_wdata | output | 6 | Full distribute row value for a write |
| bus_ack | input | 1 | One-cycle acknowledge from the bus master |
| bus_rdata | input | 10 | Scan row data, valid with bus_ack on a read |
| card_valid | output | 1 | One-cycle strobe marking a complete card word |
| card_data | output | 90 | Nine 10-bit relay row results, row 8 most significant |

## Verification
Some properties are checked by assertions on every cycle. These are: request stability, the one-bit-per-write rule against a tracked distribute image, the rule that only one relay point is closed during a trouble-card read, the single-cycle valid strobe, and what must follow a start detection or a release detection. Other behaviour can only be shown by the bench's scenarios. This covers the descending row order and point mapping, the exact dwell, settle and hold intervals measured from acknowledge to acknowledge under different bus latencies, the packing of the card word, and the release handshake for start, auxiliary start and both together.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int SCAN_W     = 10;
  localparam int DIST_W     = 6;
  localparam int DIST_ROWS  = 4;
  localparam int ADDR_W     = 4;
  localparam int RELAY_ROWS = 9;
  localparam int SLOT_W     = $clog2(RELAY_ROWS);
  localparam int CARD_W     = RELAY_ROWS * SCAN_W;
  localparam int IMG_W      = DIST_ROWS * DIST_W;
  localparam int DROW_W     = $clog2(DIST_ROWS);
  localparam int DBIT_W     = $clog2(DIST_W);

  localparam int POLL_ROW   = 0;
  localparam int START_BIT  = 9;
  localparam int AUX_BIT    = 8;
  localparam int MB_ROW     = 2;
  localparam int MB_BIT     = 0;
  localparam int DONE_ROW   = 1;
  localparam int DONE_BIT   = 5;
  localparam int LOW_GROUP  = 6;  // relay rows below this sit in distribute row 3

  typedef struct packed {
    logic [DROW_W-1:0] row;
    logic [DBIT_W-1:0] bitn;
  } dpoint_t;

  typedef enum logic [3:0] {
    ST_INIT, ST_POLL, ST_CLOSE, ST_DWELL, ST_SCAN, ST_OPEN, ST_SETTLE,
    ST_DELIVER, ST_DONE_SET, ST_RELEASE, ST_HOLD, ST_DONE_CLR
  } seq_state_e;

  function automatic dpoint_t mk_point(input int row, input int bitn);
    dpoint_t p;
    p.row  = DROW_W'(row);
    p.bitn = DBIT_W'(bitn);
    return p;
  endfunction

  // Distribute point that selects a given relay row.
  function automatic dpoint_t relay_point(input logic [SLOT_W-1:0] r);
    dpoint_t p;
    if (r < SLOT_W'(LOW_GROUP)) begin
      p.row  = DROW_W'(3);
      p.bitn = DBIT_W'(r);
    end else begin
      p.row  = DROW_W'(0);
      p.bitn = DBIT_W'(r - SLOT_W'(LOW_GROUP));
    end
    return p;
  endfunction

  // Read-modify-write of one distribute row.
  function automatic logic [DIST_W-1:0] rmw_row(input logic [DIST_W-1:0] cur,
                                                input logic [DBIT_W-1:0] b,
                                                input logic v);
    logic [DIST_W-1:0] res;
    res = cur;
    for (int i = 0; i < DIST_W; i++)
      if (b == DBIT_W'(i)) res[i] = v;
    return res;
  endfunction

  function automatic logic start_seen(input logic [SCAN_W-1:0] d);
    return d[START_BIT] | d[AUX_BIT];
  endfunction
endpackage

// File: rtl/trc_timer.sv
module trc_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt;

  assign done = run && (cnt == limit - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (done) cnt <= '0;
    else           cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/trc_dist_shadow.sv
module trc_dist_shadow
  import trc_pkg::*;
#(
  parameter logic [IMG_W-1:0] RESET_IMG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpoint_t           pt,
  input  logic              wr_val,
  input  logic              commit,
  output logic [DIST_W-1:0] row_wdata
);
  logic [DIST_W-1:0] img [DIST_ROWS];

  assign row_wdata = rmw_row(img[pt.row], pt.bitn, wr_val);

  for (genvar g = 0; g < DIST_ROWS; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        img[g] <= RESET_IMG[g*DIST_W +: DIST_W];
      else if (commit && pt.row == DROW_W'(g))
        img[g] <= row_wdata;
    end
  end
endmodule

// File: rtl/trc_card_buf.sv
module trc_card_buf
  import trc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [SLOT_W-1:0] cap_slot,
  input  logic [SCAN_W-1:0] cap_data,
  output logic [CARD_W-1:0] card
);
  for (genvar g = 0; g < RELAY_ROWS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        card[g*SCAN_W +: SCAN_W] <= '0;
      else if (cap_en && cap_slot == SLOT_W'(g))
        card[g*SCAN_W +: SCAN_W] <= cap_data;
    end
  end
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int TW          = 8,
  parameter int DWELL_CYC   = 4,
  parameter int SETTLE_CYC  = 2,
  parameter int HOLD_CYC    = 8,
  parameter int TC_SCAN_ROW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ack,
  input  logic [SCAN_W-1:0] bus_rdata,
  output dpoint_t           wr_pt,
  output logic              wr_val,
  output logic              wr_commit,
  output logic              cap_en,
  output logic [SLOT_W-1:0] cap_slot,
  output logic              tmr_run,
  output logic [TW-1:0]     tmr_limit,
  input  logic              tmr_done,
  output logic              card_valid,
  output logic              start_hit,
  output logic              release_hit
);
  localparam logic [TW-1:0] LIM_DWELL  = TW'(DWELL_CYC);
  localparam logic [TW-1:0] LIM_SETTLE = TW'(SETTLE_CYC);
  localparam logic [TW-1:0] LIM_HOLD   = TW'(HOLD_CYC);

  seq_state_e        state;
  logic [SLOT_W-1:0] row_idx;
  logic [ADDR_W-1:0] rd_addr;

  always_comb begin
    bus_req    = 1'b0;
    bus_we     = 1'b0;
    rd_addr    = ADDR_W'(POLL_ROW);
    wr_pt      = relay_point(row_idx);
    wr_val     = 1'b0;
    tmr_run    = 1'b0;
    tmr_limit  = LIM_DWELL;
    card_valid = 1'b0;
    case (state)
      ST_INIT:     begin bus_req = 1'b1; bus_we = 1'b1; wr_pt = mk_point(MB_ROW, MB_BIT); end
      ST_POLL:     bus_req = 1'b1;
      ST_CLOSE:    begin bus_req = 1'b1; bus_we = 1'b1; wr_val = 1'b1; end
      ST_DWELL:    begin tmr_run = 1'b1; tmr_limit = LIM_DWELL; end
      ST_SCAN:     begin bus_req = 1'b1; rd_addr = ADDR_W'(TC_SCAN_ROW); end
      ST_OPEN:     begin bus_req = 1'b1; bus_we = 1'b1; end
      ST_SETTLE:   begin tmr_run = 1'b1; tmr_limit = LIM_SETTLE; end
      ST_DELIVER:  card_valid = 1'b1;
      ST_DONE_SET: begin bus_req = 1'b1; bus_we = 1'b1; wr_val = 1'b1;
                         wr_pt = mk_point(DONE_ROW, DONE_BIT); end
      ST_RELEASE:  bus_req = 1'b1;
      ST_HOLD:     begin tmr_run = 1'b1; tmr_limit = LIM_HOLD; end
      ST_DONE_CLR: begin bus_req = 1'b1; bus_we = 1'b1;
                         wr_pt = mk_point(DONE_ROW, DONE_BIT); end
      default:     ;
    endcase
    bus_addr = bus_we ? ADDR_W'(wr_pt.row) : rd_addr;
  end

  assign wr_commit   = bus_req && bus_we && bus_ack;
  assign cap_en      = (state == ST_SCAN) && bus_ack;
  assign cap_slot    = row_idx;
  assign start_hit   = (state == ST_POLL) && bus_ack && start_seen(bus_rdata);
  assign release_hit = (state == ST_RELEASE) && bus_ack && !start_seen(bus_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_INIT;
      row_idx <= '0;
    end else begin
      case (state)
        ST_INIT:     if (bus_ack) state <= ST_POLL;
        ST_POLL:     if (start_hit) begin
                       row_idx <= SLOT_W'(RELAY_ROWS - 1);
                       state   <= ST_CLOSE;
                     end
        ST_CLOSE:    if (bus_ack) state <= ST_DWELL;
        ST_DWELL:    if (tmr_done) state <= ST_SCAN;
        ST_SCAN:     if (bus_ack) state <= ST_OPEN;
        ST_OPEN:     if (bus_ack) state <= ST_SETTLE;
        ST_SETTLE:   if (tmr_done) begin
                       if (row_idx == '0) state <= ST_DELIVER;
                       else begin
                         row_idx <= row_idx - SLOT_W'(1);
                         state   <= ST_CLOSE;
                       end
                     end
        ST_DELIVER:  state <= ST_DONE_SET;
        ST_DONE_SET: if (bus_ack) state <= ST_RELEASE;
        ST_RELEASE:  if (release_hit) state <= ST_HOLD;
        ST_HOLD:     if (tmr_done) state <= ST_DONE_CLR;
        ST_DONE_CLR: if (bus_ack) state <= ST_POLL;
        default:     state <= ST_INIT;
      endcase
    end
  end
endmodule

// File: rtl/trc_sequencer.sv
module trc_sequencer
  import trc_pkg::*;
#(
  parameter int               DWELL_CYC   = 3_200_000,
  parameter int               SETTLE_CYC  = 10_000,
  parameter int               HOLD_CYC    = 50_000_000,
  parameter int               TC_SCAN_ROW = 4,
  parameter logic [IMG_W-1:0] DIST_RESET  = 24'h001000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DIST_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [SCAN_W-1:0] bus_rdata,
  output logic              card_valid,
  output logic [CARD_W-1:0] card_data
);
  localparam int MAX_A  = (DWELL_CYC > SETTLE_CYC) ? DWELL_CYC : SETTLE_CYC;
  localparam int MAX_LIM = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int TW     = $clog2(MAX_LIM + 1) + 1;

  dpoint_t           wr_pt;
  logic              wr_val, wr_commit, cap_en;
  logic [SLOT_W-1:0] cap_slot;
  logic              tmr_run, tmr_done;
  logic [TW-1:0]     tmr_limit;
  logic              start_hit, release_hit;

  trc_ctrl #(
    .TW(TW), .DWELL_CYC(DWELL_CYC), .SETTLE_CYC(SETTLE_CYC),
    .HOLD_CYC(HOLD_CYC), .TC_SCAN_ROW(TC_SCAN_ROW)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .wr_pt(wr_pt), .wr_val(wr_val), .wr_commit(wr_commit),
    .cap_en(cap_en), .cap_slot(cap_slot),
    .tmr_run(tmr_run), .tmr_limit(tmr_limit), .tmr_done(tmr_done),
    .card_valid(card_valid), .start_hit(start_hit), .release_hit(release_hit)
  );

  trc_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(tmr_limit), .done(tmr_done)
  );

  trc_dist_shadow #(.RESET_IMG(DIST_RESET)) shadow_i (
    .clk(clk), .rst_n(rst_n), .pt(wr_pt), .wr_val(wr_val),
    .commit(wr_commit), .row_wdata(bus_wdata)
  );

  trc_card_buf card_i (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_slot(cap_slot),
    .cap_data(bus_rdata), .card(card_data)
  );
endmodule

// File: rtl/trc_sequencer_chk.sv
module trc_sequencer_chk
  import trc_pkg::*;
#(
  parameter int               TC_SCAN_ROW = 4,
  parameter logic [IMG_W-1:0] DIST_RESET  = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DIST_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              card_valid,
  input logic              start_hit,
  input logic              release_hit
);
  // Image of the distribute field as seen on the bus.
  logic [IMG_W-1:0] seen;
  logic [DIST_W-1:0] seen_row;
  logic [RELAY_ROWS-1:0] relay_closed;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= DIST_RESET;
    else if (bus_req && bus_we && bus_ack)
      seen[bus_addr[DROW_W-1:0]*DIST_W +: DIST_W] <= bus_wdata;
  end

  assign seen_row     = seen[bus_addr[DROW_W-1:0]*DIST_W +: DIST_W];
  assign relay_closed = {seen[2:0], seen[3*DIST_W +: LOW_GROUP]};

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  assert_one_bit_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_ack |-> $countones(bus_wdata ^ seen_row) <= 1);

  assert_write_row_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_addr < ADDR_W'(DIST_ROWS));

  assert_single_relay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && bus_addr == ADDR_W'(TC_SCAN_ROW) |-> $countones(relay_closed) == 1);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    card_valid |=> !card_valid);

  assert_done_open_at_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    card_valid |-> !seen[DONE_ROW*DIST_W + DONE_BIT]);

  assert_start_closes_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> bus_req && bus_we && bus_addr == '0);

  assert_release_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    release_hit |=> !bus_req);
endmodule

bind trc_sequencer trc_sequencer_chk #(
  .TC_SCAN_ROW(TC_SCAN_ROW), .DIST_RESET(DIST_RESET)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .card_valid(card_valid), .start_hit(start_hit), .release_hit(release_hit)
);

// File: tb/trc_sequencer_tb.sv
module trc_sequencer_tb_top;
  localparam int DW = 20;
  localparam int SW = 3;
  localparam int HW = 40;
  localparam int TC = 4;
  localparam logic [23:0] PRE = 24'h011110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        bus_req, bus_we, bus_ack, card_valid;
  logic [3:0]  bus_addr;
  logic [5:0]  bus_wdata;
  logic [9:0]  bus_rdata;
  logic [89:0] card_data;

  trc_sequencer #(
    .DWELL_CYC(DW), .SETTLE_CYC(SW), .HOLD_CYC(HW), .TC_SCAN_ROW(TC), .DIST_RESET(PRE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .card_valid(card_valid), .card_data(card_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- bus master model ----------------
  int   lat = 0;
  bit   s_start = 1'b0, s_aux = 1'b0;
  int   seed = 1;
  logic [5:0] dimg [4];
  logic ack_r = 1'b0;
  logic [9:0] rdata_r = '0;
  int   lcnt = 0;
  assign bus_ack   = ack_r;
  assign bus_rdata = rdata_r;

  function automatic logic [9:0] pat(input int r, input int s);
    return 10'((r * 73 + s * 211 + 17) % 1024);
  endfunction

  function automatic logic [9:0] respond(input logic [3:0] a);
    int hits = 0;
    int which = 0;
    if (a == 4'd0) return {s_start, s_aux, 8'h00};
    if (a == 4'(TC)) begin
      for (int k = 0; k < 9; k++) begin
        if ((k < 6) ? dimg[3][k] : dimg[0][k-6]) begin
          hits++;
          which = k;
        end
      end
      return (hits == 1) ? pat(which, seed) : 10'h000;
    end
    return 10'h000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ack_r <= 1'b0;
      lcnt  <= 0;
      for (int i = 0; i < 4; i++) dimg[i] <= PRE[i*6 +: 6];
    end else if (ack_r) begin
      ack_r <= 1'b0;
    end else if (bus_req) begin
      if (lcnt >= lat) begin
        ack_r   <= 1'b1;
        lcnt    <= 0;
        rdata_r <= bus_we ? 10'h000 : respond(bus_addr);
        if (bus_we) dimg[bus_addr[1:0]] <= bus_wdata;
      end else lcnt <= lcnt + 1;
    end else lcnt <= 0;
  end

  // ---------------- per-clock monitors ----------------
  int          n_valid = 0;
  int          v_cyc = 0;
  logic [89:0] v_data = '0;
  logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [3:0]  p_addr = '0;
  logic [5:0]  p_wd = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (card_valid) begin
        n_valid++;
        v_cyc  = cyc;
        v_data = card_data;
      end
      if (p_req && !p_ack)
        check(bus_req && bus_we == p_we && bus_addr == p_addr && bus_wdata == p_wd,
              "R10", "request changed before acknowledge",
              {bus_req, bus_we, bus_addr, bus_wdata}, {1'b1, p_we, p_addr, p_wd});
    end
    p_req  = bus_req && rst_n;
    p_ack  = bus_ack;
    p_we   = bus_we;
    p_addr = bus_addr;
    p_wd   = bus_wdata;
  end

  // ---------------- reference sequence ----------------
  logic [5:0] ref_img [4];
  int last_ack = 0;

  task automatic get_txn(output bit we, output logic [3:0] a, output logic [5:0] wd,
                         output logic [9:0] rd, output int gap);
    do @(negedge clk); while (!bus_ack);
    we  = bus_we;
    a   = bus_addr;
    wd  = bus_wdata;
    rd  = bus_rdata;
    gap = cyc - last_ack;
    last_ack = cyc;
  endtask

  task automatic expect_write(input int row, input int b, input bit v, input int gap_exp,
                              input bit chk_gap, input string tag);
    bit we; logic [3:0] a; logic [5:0] wd; logic [9:0] rd; int gap;
    logic [5:0] exp;
    get_txn(we, a, wd, rd, gap);
    exp = ref_img[row];
    exp[b] = v;
    check(we == 1'b1, tag, "expected a write", we, 1);
    check(a == 4'(row), tag, "write row", a, row);
    check(wd == exp, "R9", "row data after one-point change", wd, exp);
    if (chk_gap) check(gap == gap_exp, tag, "cycles since previous acknowledge", gap, gap_exp);
    ref_img[row] = exp;
  endtask

  task automatic expect_read(input int addr, input int gap_exp, input string tag,
                             output logic [9:0] rd);
    bit we; logic [3:0] a; logic [5:0] wd; int gap;
    get_txn(we, a, wd, rd, gap);
    check(we == 1'b0, tag, "expected a read", we, 0);
    check(a == 4'(addr), tag, "read row", a, addr);
    check(gap == gap_exp, tag, "cycles since previous acknowledge", gap, gap_exp);
  endtask

  task automatic run_card(input int L, input bit st, input bit ax, input int sd);
    logic [9:0]  rd;
    logic [89:0] exp_card;
    int          t_open, v_before;
    lat = L;
    seed = sd;
    for (int i = 0; i < 3; i++) begin
      expect_read(0, L + 2, "R2", rd);
      check(!bus_req || !bus_we, "R2", "idle issues no write", bus_we, 0);
    end
    s_start = st;
    s_aux   = ax;
    expect_read(0, L + 2, "R3", rd);
    check(rd[9] | rd[8], "R3", "start indication returned", rd, {st, ax, 8'h00});
    v_before = n_valid;
    exp_card = '0;
    for (int r = 8; r >= 0; r--) begin
      int prow = (r < 6) ? 3 : 0;
      int pbit = (r < 6) ? r : r - 6;
      expect_write(prow, pbit, 1'b1, (r == 8) ? L + 2 : SW + L + 2, 1'b1, "R4");
      expect_read(TC, DW + L + 2, "R5", rd);
      expect_write(prow, pbit, 1'b0, L + 2, 1'b1, "R5");
      exp_card[r*10 +: 10] = pat(r, sd);
    end
    t_open = last_ack;
    expect_write(1, 5, 1'b1, SW + 1 + L + 2, 1'b1, "R7");
    check(n_valid == v_before + 1, "R6", "valid pulses for one card", n_valid - v_before, 1);
    check(v_cyc == t_open + SW + 1, "R6", "valid cycle", v_cyc, t_open + SW + 1);
    check(v_data == exp_card, "R6", "card word", v_data, exp_card);
    for (int i = 0; i < 2; i++) begin
      expect_read(0, L + 2, "R7", rd);
      check(rd[9] | rd[8], "R7", "start still present during release poll", rd, {st, ax, 8'h00});
    end
    s_start = 1'b0;
    s_aux   = 1'b0;
    expect_read(0, L + 2, "R7", rd);
    expect_write(1, 5, 1'b0, HW + L + 2, 1'b1, "R8");
  endtask

  initial begin
    logic [9:0] rd;
    for (int i = 0; i < 4; i++) ref_img[i] = PRE[i*6 +: 6];
    repeat (4) @(negedge clk);
    check(card_valid == 1'b0, "R1", "card_valid in reset", card_valid, 0);
    check(card_data == '0, "R1", "card_data in reset", card_data, 0);
    rst_n = 1'b1;
    last_ack = cyc;
    expect_write(2, 0, 1'b0, 0, 1'b0, "R1");
    run_card(0, 1'b1, 1'b0, 1);
    run_card(2, 1'b0, 1'b1, 2);
    run_card(1, 1'b1, 1'b1, 3);
    expect_read(0, 3, "R8", rd);
    check(n_valid == 3, "R6", "total valid pulses", n_valid, 3);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog: actual=hung expected=sequence complete");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule